// File: doc/BRIEF.md
# Table-Indexed Compressed Jump Unit

This unit executes the 16-bit table-jump instruction. It keeps a jump-vector control register whose upper field is the table base. The base is aligned to 64 bytes and filled out with zeros in its low six bits. The register's low six bits hold a mode selector. When an instruction is issued, the unit takes an 8-bit table index from the instruction and forms the address of the table entry. It reads one machine word from memory at that address and then redirects the program counter to the word it read.

If the index is 32 or more, the instruction also links. The unit writes the address of the next instruction (issue PC + 2) to the return-address register in the same cycle as the redirect. If the mode the software last wrote is not zero, the instruction counts as reserved. The unit then raises an illegal-instruction pulse and does no memory access, no redirect and no link.

The control register follows write-any/read-legal rules. Any value can be written, but a read always returns mode zero. A parameter selects a 32-bit or 64-bit machine word, and the word size sets the table entry stride (4 or 8 bytes).

Top module: `tbljmp_unit`

## Requirements
- R1: `csr_rdata` reads as zero after reset. After a write it returns the written bits XLEN-1..6 with bits 5..0 forced to zero, even when a nonzero mode was written.
- R2: After a write whose bits 5..0 are nonzero, each accepted issue raises `illegal` for exactly one cycle, the cycle after the issue. It makes no memory request, no redirect and no `ra_we`. A later write with bits 5..0 equal to zero makes issues legal again.
- R3: The table index is `issue_instr[9:2]`. In the cycle after a legal issue, `mem_req_valid` is high for exactly one cycle. `mem_req_addr` then equals the 64-byte-aligned base plus the index shifted left by 2 (XLEN=32) or by 3 (XLEN=64).
- R4: `busy` is high from the cycle after a legal issue up to and including the cycle in which the response is taken. An issue presented while `busy` is high is ignored.
- R5: One cycle after `mem_resp_valid` is sampled while waiting, `redirect_valid` pulses for one cycle with `redirect_pc` equal to the response data.
- R6: If the index is 32 or more, `ra_we` pulses in the redirect cycle with `ra_wdata` = issue PC + 2. If the index is 31 or less, `ra_we` stays low.
- R7: A `mem_resp_valid` that arrives while no request is outstanding causes no redirect, no link and no change of `busy`.
- R8: An issue uses the control-register value from before any write in the same cycle. A write made while busy does not change the address or target of the instruction in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Jump-vector register write strobe |
| csr_wdata | input | XLEN | Write value |
| csr_rdata | output | XLEN | Legal read value of the register |
| issue_valid | input | 1 | Table-jump instruction presented |
| issue_instr | input | 16 | Instruction bits |
| issue_pc | input | XLEN | Address of the instruction |
| busy | output | 1 | Instruction in flight |
| mem_req_valid | output | 1 | Table read request |
| mem_req_addr | output | XLEN | Table entry address |
| mem_resp_valid | input | 1 | Read data valid |
| mem_resp_data | input | XLEN | Read data (jump target) |
| redirect_valid | output | 1 | PC redirect pulse |
| redirect_pc | output | XLEN | New PC |
| ra_we | output | 1 | Return-address write pulse |
| ra_wdata | output | XLEN | Return address |
| illegal | output | 1 | Illegal-instruction pulse |

## Verification
The case where two functions meet in one cycle is a control-register write landing in the same cycle as an issue. The bench provokes it by driving `csr_we` together with `issue_valid`, once with a new base and once with a reserved mode. The requested address must come from the old base, and legality must follow the old mode. A second collision writes the register while a request is outstanding. In that case the request address and the redirect target must not change.

// File: rtl/tbljmp_pkg.sv
package tbljmp_pkg;
  localparam int unsigned MODE_W   = 6;
  localparam int unsigned IDX_W    = 8;
  localparam int unsigned IDX_LSB  = 2;
  localparam int unsigned LINK_MIN = 32;

  typedef enum logic [1:0] {
    TJ_IDLE = 2'd0,
    TJ_REQ  = 2'd1,
    TJ_WAIT = 2'd2
  } tj_state_e;

  function automatic int unsigned entry_shift(input int unsigned xlen);
    return (xlen == 64) ? 3 : 2;
  endfunction
endpackage

// File: rtl/tbljmp_rst_sync.sv
module tbljmp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tbljmp_vec_csr.sv
module tbljmp_vec_csr
  import tbljmp_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic [XLEN-1:0] base_addr,
  output logic            mode_bad
);
  localparam int unsigned BASE_W = XLEN - MODE_W;

  logic [BASE_W-1:0] base_q, base_d;
  logic              bad_q, bad_d;

  always_comb begin
    base_d = base_q;
    bad_d  = bad_q;
    if (csr_we) begin
      base_d = csr_wdata[XLEN-1:MODE_W];
      bad_d  = |csr_wdata[MODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      bad_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      bad_q  <= bad_d;
    end
  end

  assign base_addr = {base_q, {MODE_W{1'b0}}};
  assign csr_rdata = base_addr;
  assign mode_bad  = bad_q;

  AST_CSR_BASE_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |=> csr_rdata[XLEN-1:MODE_W] == $past(csr_wdata[XLEN-1:MODE_W])); // R1
  AST_CSR_BAD_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |=> mode_bad == $past(|csr_wdata[MODE_W-1:0])); // R2
endmodule

// File: rtl/tbljmp_decode.sv
module tbljmp_decode
  import tbljmp_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [15:0]     instr,
  input  logic [XLEN-1:0] base_addr,
  output logic [XLEN-1:0] entry_addr,
  output logic            link
);
  localparam int unsigned SH = entry_shift(XLEN);

  logic [IDX_W-1:0] idx;
  logic [XLEN-1:0]  offset;
  logic             unused_bits;

  assign idx         = instr[IDX_LSB +: IDX_W];
  assign unused_bits = ^{instr[15:IDX_LSB+IDX_W], instr[IDX_LSB-1:0]};

  generate
    if (SH == 3) begin : g_stride8
      assign offset = {{(XLEN-IDX_W-3){1'b0}}, idx, 3'b000};
    end else begin : g_stride4
      assign offset = {{(XLEN-IDX_W-2){1'b0}}, idx, 2'b00};
    end
  endgenerate

  assign entry_addr = base_addr + offset;
  assign link       = (idx >= IDX_W'(LINK_MIN));
endmodule

// File: rtl/tbljmp_ctrl.sv
module tbljmp_ctrl
  import tbljmp_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [XLEN-1:0] issue_pc,
  input  logic [XLEN-1:0] entry_addr,
  input  logic            link,
  input  logic            mode_bad,
  input  logic            mem_resp_valid,
  input  logic [XLEN-1:0] mem_resp_data,
  output logic            busy,
  output logic            mem_req_valid,
  output logic [XLEN-1:0] mem_req_addr,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            ra_we,
  output logic [XLEN-1:0] ra_wdata,
  output logic            illegal
);
  tj_state_e       st_q, st_d;
  logic            load_en, take_en, ill_d;
  logic [XLEN-1:0] addr_q, ret_q, tgt_q;
  logic            link_q, redir_q, ra_we_q, ill_q;

  always_comb begin
    st_d    = st_q;
    load_en = 1'b0;
    take_en = 1'b0;
    ill_d   = 1'b0;
    unique case (st_q)
      TJ_IDLE: if (issue_valid) begin
        if (mode_bad) ill_d = 1'b1;
        else begin
          load_en = 1'b1;
          st_d    = TJ_REQ;
        end
      end
      TJ_REQ:  st_d = TJ_WAIT;
      TJ_WAIT: if (mem_resp_valid) begin
        take_en = 1'b1;
        st_d    = TJ_IDLE;
      end
      default: st_d = TJ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TJ_IDLE;
      redir_q <= 1'b0;
      ra_we_q <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      redir_q <= take_en;
      ra_we_q <= take_en & link_q;
      ill_q   <= ill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      addr_q <= entry_addr;
      ret_q  <= issue_pc + XLEN'(2);
      link_q <= link;
    end
    if (take_en) tgt_q <= mem_resp_data;
  end

  assign busy           = (st_q != TJ_IDLE);
  assign mem_req_valid  = (st_q == TJ_REQ);
  assign mem_req_addr   = addr_q;
  assign redirect_valid = redir_q;
  assign redirect_pc    = tgt_q;
  assign ra_we          = ra_we_q;
  assign ra_wdata       = ret_q;
  assign illegal        = ill_q;

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid); // R3
  AST_BUSY_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && issue_valid && !mode_bad) |=> (busy && mem_req_valid)); // R4
  AST_REDIR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid); // R5
  AST_LINK_WITH_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    ra_we |-> redirect_valid); // R6
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!busy && !redirect_valid && !ra_we)); // R2
  AST_IDLE_RESP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mem_resp_valid) |=> !redirect_valid); // R7
endmodule

// File: rtl/tbljmp_unit.sv
module tbljmp_unit
  import tbljmp_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            issue_valid,
  input  logic [15:0]     issue_instr,
  input  logic [XLEN-1:0] issue_pc,
  output logic            busy,
  output logic            mem_req_valid,
  output logic [XLEN-1:0] mem_req_addr,
  input  logic            mem_resp_valid,
  input  logic [XLEN-1:0] mem_resp_data,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            ra_we,
  output logic [XLEN-1:0] ra_wdata,
  output logic            illegal
);
  logic            rst_sync_n;
  logic [XLEN-1:0] base_addr, entry_addr;
  logic            mode_bad, link;

  tbljmp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tbljmp_vec_csr #(.XLEN(XLEN)) u_csr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .csr_we    (csr_we),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .base_addr (base_addr),
    .mode_bad  (mode_bad)
  );

  tbljmp_decode #(.XLEN(XLEN)) u_dec (
    .instr      (issue_instr),
    .base_addr  (base_addr),
    .entry_addr (entry_addr),
    .link       (link)
  );

  tbljmp_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .issue_valid    (issue_valid),
    .issue_pc       (issue_pc),
    .entry_addr     (entry_addr),
    .link           (link),
    .mode_bad       (mode_bad),
    .mem_resp_valid (mem_resp_valid),
    .mem_resp_data  (mem_resp_data),
    .busy           (busy),
    .mem_req_valid  (mem_req_valid),
    .mem_req_addr   (mem_req_addr),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .ra_we          (ra_we),
    .ra_wdata       (ra_wdata),
    .illegal        (illegal)
  );
endmodule

// File: tb/tbljmp_unit_tb.sv
module tbljmp_unit_tb;
  localparam int unsigned XLEN = 32;
  localparam int unsigned ESZ  = XLEN / 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            csr_we = 1'b0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [XLEN-1:0] csr_rdata;
  logic            issue_valid = 1'b0;
  logic [15:0]     issue_instr = '0;
  logic [XLEN-1:0] issue_pc = '0;
  logic            busy, mem_req_valid, redirect_valid, ra_we, illegal;
  logic [XLEN-1:0] mem_req_addr, redirect_pc, ra_wdata;
  logic            mem_resp_valid = 1'b0;
  logic [XLEN-1:0] mem_resp_data = '0;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tbljmp_unit #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .issue_valid(issue_valid), .issue_instr(issue_instr),
    .issue_pc(issue_pc), .busy(busy), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_resp_valid(mem_resp_valid),
    .mem_resp_data(mem_resp_data), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .ra_we(ra_we), .ra_wdata(ra_wdata),
    .illegal(illegal)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [XLEN-1:0] tgt_of(input logic [XLEN-1:0] a);
    return {a[XLEN-2:0], 1'b0} ^ 32'h4000_0000;
  endfunction

  // ---------------- behavioural reference model ----------------
  int              m_st = 0;
  logic [XLEN-1:0] m_base = '0, m_addr = '0, m_ret = '0, m_pc = '0;
  bit              m_bad = 0, m_link = 0, m_redir = 0, m_ra = 0, m_ill = 0;
  int              rst_cnt = 0;
  bit              live = 0;

  always @(posedge clk) begin
    if (!rst_n || rst_cnt < 2) begin
      if (!rst_n) rst_cnt = 0; else rst_cnt++;
      m_st = 0; m_base = '0; m_bad = 0; m_redir = 0; m_ra = 0; m_ill = 0;
    end else begin
      int idx;
      m_redir = 0; m_ra = 0; m_ill = 0;
      idx = int'(issue_instr[9:2]);
      if (m_st == 0) begin
        if (issue_valid) begin
          if (m_bad) m_ill = 1;
          else begin
            m_addr = m_base + XLEN'(idx * ESZ);
            m_link = (idx >= 32);
            m_ret  = issue_pc + 2;
            m_st   = 1;
          end
        end
      end else if (m_st == 1) m_st = 2;
      else if (mem_resp_valid) begin
        m_redir = 1; m_pc = mem_resp_data; m_ra = m_link; m_st = 0;
      end
      if (csr_we) begin
        m_base = {csr_wdata[XLEN-1:6], 6'b0};
        m_bad  = (csr_wdata[5:0] != 0);
      end
    end
    live = 1;
  end

  always @(negedge clk) begin
    if (live) begin
      chk("R1 csr_rdata", csr_rdata, m_base);
      chk("R4 busy", busy, m_st != 0);
      chk("R3 mem_req_valid", mem_req_valid, m_st == 1);
      if (m_st == 1) chk("R3 mem_req_addr", mem_req_addr, m_addr);
      chk("R5 redirect_valid", redirect_valid, m_redir);
      if (m_redir) chk("R5 redirect_pc", redirect_pc, m_pc);
      chk("R6 ra_we", ra_we, m_ra);
      if (m_ra) chk("R6 ra_wdata", ra_wdata, m_ret);
      chk("R2 illegal", illegal, m_ill);
    end
  end

  // ---------------- behavioural memory ----------------
  int              mem_lat = 1;
  int              pend = 0;
  logic [XLEN-1:0] pend_addr = '0;
  logic [XLEN-1:0] last_req = '0;
  bit              spur = 0;

  always @(negedge clk) begin
    mem_resp_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_resp_valid = 1'b1;
        mem_resp_data  = tgt_of(pend_addr);
      end
    end
    if (spur) begin
      mem_resp_valid = 1'b1;
      mem_resp_data  = 32'hDEAD_BEE0;
      spur = 0;
    end
    if (mem_req_valid === 1'b1) begin
      pend = mem_lat; pend_addr = mem_req_addr; last_req = mem_req_addr;
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [15:0] enc(input int idx);
    return {6'b101000, 8'(idx), 2'b10};
  endfunction

  task automatic csr_write(input logic [XLEN-1:0] v);
    @(negedge clk); csr_we = 1'b1; csr_wdata = v;
    @(negedge clk); csr_we = 1'b0;
  endtask

  task automatic jump(input int idx, input logic [XLEN-1:0] pc, input int lat);
    @(negedge clk);
    mem_lat = lat; issue_valid = 1'b1; issue_instr = enc(idx); issue_pc = pc;
    @(negedge clk); issue_valid = 1'b0;
    repeat (lat + 4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset csr_rdata", csr_rdata, '0);

    csr_write(32'h0001_2000);
    jump(5, 32'h0000_0100, 1);    // R5 plain jump
    jump(31, 32'h0000_0200, 2);   // R6 boundary, no link
    jump(32, 32'h0000_0300, 3);   // R6 boundary, link
    jump(255, 32'h0000_0400, 1);  // R3 top entry
    jump(0, 32'h0000_0500, 5);    // R3 first entry

    // R1/R2: reserved mode stays hidden on read, issue becomes illegal
    csr_write(32'h0003_4007);
    chk("R1 mode masked", csr_rdata, 32'h0003_4000);
    jump(40, 32'h0000_0600, 1);
    csr_write(32'h0003_4000);
    jump(40, 32'h0000_0600, 1);

    // R4: second issue while busy is ignored
    @(negedge clk);
    mem_lat = 4; issue_valid = 1'b1; issue_instr = enc(33); issue_pc = 32'h700;
    @(negedge clk); issue_instr = enc(2); issue_pc = 32'h800;
    @(negedge clk); issue_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk("R4 busy-issue ignored", last_req, 32'h0003_4000 + 33 * ESZ);

    // R7: response with nothing outstanding
    @(posedge clk); spur = 1;
    @(negedge clk); @(negedge clk);
    chk("R7 no redirect", redirect_valid, 1'b0);
    repeat (2) @(negedge clk);

    // R8: write in the same cycle as issue uses the old base
    @(negedge clk);
    mem_lat = 2; issue_valid = 1'b1; issue_instr = enc(7); issue_pc = 32'h900;
    csr_we = 1'b1; csr_wdata = 32'h0055_0000;
    @(negedge clk); issue_valid = 1'b0; csr_we = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 old base used", last_req, 32'h0003_4000 + 7 * ESZ);

    // R8: write of reserved mode with issue in same cycle stays legal
    @(negedge clk);
    mem_lat = 1; issue_valid = 1'b1; issue_instr = enc(50); issue_pc = 32'hA00;
    csr_we = 1'b1; csr_wdata = 32'h0066_0001;
    @(negedge clk); issue_valid = 1'b0; csr_we = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 old mode used", last_req, 32'h0055_0000 + 50 * ESZ);
    jump(50, 32'hA00, 1); // R2 now illegal

    // R8: write while request outstanding
    csr_write(32'h0077_0000);
    @(negedge clk);
    mem_lat = 3; issue_valid = 1'b1; issue_instr = enc(9); issue_pc = 32'hB00;
    @(negedge clk); issue_valid = 1'b0; csr_we = 1'b1; csr_wdata = 32'h0011_0000;
    @(negedge clk); csr_we = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 in-flight address kept", last_req, 32'h0077_0000 + 9 * ESZ);
    jump(100, 32'hC00, 2);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule